// File: doc/BRIEF.md
# Nibble-Loaded Pattern Bank Mapper

This block translates a 13-bit graphics pattern address into a wider pattern-ROM address. It holds eight bank registers of 8 bits each. Graphics address bits [12:10] pick one of the eight 1 KB windows, and the register for that window supplies the upper bits of the ROM address. The low ten graphics address bits pass through unchanged.

The CPU loads the bank registers through its write port, four bits per write. Writes land in four 4 KB pages of the CPU map. Two sub-address select bits pick the register within a page and the nibble within the register. Each select bit is the OR of two CPU address lines. Boards wire these lines differently, so a synthesis-time variant parameter chooses the line pairs.

A bypass input covers boards that use 8 KB of pattern RAM in place of ROM. While the bypass is high, the graphics address passes straight through and the bank registers are ignored. Pattern storage itself lies outside this block.

Top module: `pattern_bank_map`

## Requirements
- R1: After reset is released, register i holds the value i, so the output for graphics window i is (i << 10) | gfx_addr[9:0].
- R2: A write hits the bank registers only when cpu_addr[15:12] is 0xB, 0xC, 0xD or 0xE. The register index is 2*(cpu_addr[15:12] - 0xB) + sel_hi. A write to any other page changes no register.
- R3: A hitting write with sel_lo = 0 replaces bits [3:0] of the chosen register with cpu_data[3:0] and leaves bits [7:4] unchanged.
- R4: A hitting write with sel_lo = 1 replaces bits [7:4] of the chosen register with cpu_data[3:0] and leaves bits [3:0] unchanged. cpu_data[7:4] is never used.
- R5: With VARIANT = WIRE_A (the default), sel_lo = A1|A6 and sel_hi = A2|A7.
- R6: With VARIANT = WIRE_B, sel_lo = A2|A0 and sel_hi = A3|A1. With VARIANT = WIRE_C, sel_lo = A3|A1 and sel_hi = A2|A0.
- R7: When ram_bypass is low, pat_addr = {bank[gfx_addr[12:10]], gfx_addr[9:0]}. The value is truncated to ROM_AW bits when ROM_AW < 18 and zero-extended when ROM_AW > 18.
- R8: When ram_bypass is high, pat_addr is gfx_addr[12:0] zero-extended, and the bank register contents have no effect on it. Writes still update the registers during bypass.
- R9: A register write shows on pat_addr from the first clock edge that samples cpu_wr high. Any address or data presented with cpu_wr low changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronised inside the block |
| cpu_wr | input | 1 | CPU write strobe, one cycle per write |
| cpu_addr | input | 16 | CPU write address |
| cpu_data | input | 8 | CPU write data; only bits [3:0] are used |
| gfx_addr | input | 13 | Graphics pattern address |
| ram_bypass | input | 1 | High when pattern RAM is fitted; the banking is skipped |
| pat_addr | output | ROM_AW | Translated pattern-memory address |

## Verification
The translation from gfx_addr to pat_addr is purely combinational. The bench changes gfx_addr on a falling edge and samples pat_addr one nanosecond later, before the next rising edge.

A write is presented on a falling edge and captured on the following rising edge. Its effect is checked on the next falling edge, after the strobe has been dropped. This places every check exactly one register stage after its stimulus.

Reset release passes through a two-stage synchroniser. The reset values are therefore checked three cycles after rst_n rises. Three instances with different wiring variants and ROM widths share the same stimulus, so the same write sequence exercises each decoder.

// File: rtl/pbm_pkg.sv
package pbm_pkg;
  typedef enum logic [1:0] {
    WIRE_A = 2'd0,
    WIRE_B = 2'd1,
    WIRE_C = 2'd2
  } wiring_e;

  localparam int CPU_AW     = 16;
  localparam int CPU_DW     = 8;
  localparam int GFX_AW     = 13;
  localparam int BANK_W     = 8;
  localparam int NUM_BANKS  = 8;
  localparam int OFS_W      = 10;
  localparam int PAGE_W     = 4;
  localparam logic [PAGE_W-1:0] FIRST_PAGE = 4'hB;
  localparam logic [PAGE_W-1:0] LAST_PAGE  = 4'hE;
  localparam int DEC_AW     = 8;
endpackage

// File: rtl/pbm_sel_decode.sv
module pbm_sel_decode
  import pbm_pkg::*;
#(
  parameter wiring_e VARIANT = WIRE_A,
  parameter int      DEC_W   = DEC_AW
) (
  input  logic [DEC_W-1:0] addr_lo,
  output logic             sel_lo,
  output logic             sel_hi
);
  // Each select bit ORs two address lines; the board wiring decides which.
  generate
    if (VARIANT == WIRE_B) begin : g_wire_b
      assign sel_lo = addr_lo[2] | addr_lo[0];
      assign sel_hi = addr_lo[3] | addr_lo[1];
    end else if (VARIANT == WIRE_C) begin : g_wire_c
      assign sel_lo = addr_lo[3] | addr_lo[1];
      assign sel_hi = addr_lo[2] | addr_lo[0];
    end else begin : g_wire_a
      assign sel_lo = addr_lo[1] | addr_lo[6];
      assign sel_hi = addr_lo[2] | addr_lo[7];
    end
  endgenerate

  logic unused_dec_bits;
  assign unused_dec_bits = ^addr_lo;
endmodule

// File: rtl/pbm_bank_file.sv
module pbm_bank_file
  import pbm_pkg::*;
#(
  parameter int N_BANK = NUM_BANKS,
  parameter int BW     = BANK_W
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [$clog2(N_BANK)-1:0] wr_idx,
  input  logic                      wr_hi,
  input  logic [BW/2-1:0]           wr_nib,
  input  logic [$clog2(N_BANK)-1:0] rd_idx,
  output logic [BW-1:0]             rd_bank
);
  localparam int NIB_W = BW / 2;

  logic [N_BANK-1:0][BW-1:0] bank_q;
  logic [N_BANK-1:0][BW-1:0] bank_d;

  // Next state: patch one nibble of the chosen register.
  always_comb begin
    bank_d = bank_q;
    if (wr_hi) begin
      bank_d[wr_idx][BW-1:NIB_W] = wr_nib;
    end else begin
      bank_d[wr_idx][NIB_W-1:0] = wr_nib;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_BANK; i++) begin
        bank_q[i] <= BW'(i);
      end
    end else if (wr_en) begin
      bank_q <= bank_d;
    end
  end

  assign rd_bank = bank_q[rd_idx];

  // R3: a low-nibble write loads bits [3:0] and keeps the upper nibble
  a_r3_low_nibble: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_hi) |=>
      (bank_q[$past(wr_idx)][NIB_W-1:0] == $past(wr_nib)) &&
      (bank_q[$past(wr_idx)][BW-1:NIB_W] == $past(bank_q[wr_idx][BW-1:NIB_W])));

  // R4: a high-nibble write loads bits [7:4] and keeps the lower nibble
  a_r4_high_nibble: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_hi) |=>
      (bank_q[$past(wr_idx)][BW-1:NIB_W] == $past(wr_nib)) &&
      (bank_q[$past(wr_idx)][NIB_W-1:0] == $past(bank_q[wr_idx][NIB_W-1:0])));

  // R9: with no write the whole register file holds
  a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(bank_q));
endmodule

// File: rtl/pbm_xlate.sv
module pbm_xlate
  import pbm_pkg::*;
#(
  parameter int BW     = BANK_W,
  parameter int OW     = OFS_W,
  parameter int GW     = GFX_AW,
  parameter int ROM_AW = BANK_W + OFS_W
) (
  input  logic [BW-1:0]     bank,
  input  logic [GW-1:0]     gfx_addr,
  input  logic              bypass,
  output logic [ROM_AW-1:0] pat_addr
);
  localparam int FULL_W = BW + OW;

  logic [FULL_W-1:0] full_addr;

  always_comb begin
    if (bypass) begin
      full_addr = {{(FULL_W-GW){1'b0}}, gfx_addr};
    end else begin
      full_addr = {bank, gfx_addr[OW-1:0]};
    end
  end

  // Fit the full address to the fitted ROM size.
  generate
    if (ROM_AW <= FULL_W) begin : g_trunc
      assign pat_addr = full_addr[ROM_AW-1:0];
      if (ROM_AW < FULL_W) begin : g_drop
        logic unused_hi_bits;
        assign unused_hi_bits = ^full_addr[FULL_W-1:ROM_AW];
      end
    end else begin : g_extend
      assign pat_addr = {{(ROM_AW-FULL_W){1'b0}}, full_addr};
    end
  endgenerate
endmodule

// File: rtl/pattern_bank_map.sv
module pattern_bank_map
  import pbm_pkg::*;
#(
  parameter wiring_e VARIANT = WIRE_A,
  parameter int      ROM_AW  = BANK_W + OFS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_wr,
  input  logic [15:0]       cpu_addr,
  input  logic [7:0]        cpu_data,
  input  logic [12:0]       gfx_addr,
  input  logic              ram_bypass,
  output logic [ROM_AW-1:0] pat_addr
);
  localparam int IDX_W = $clog2(NUM_BANKS);
  localparam int NIB_W = BANK_W / 2;

  // Reset: asynchronous assert, synchronous release.
  logic [1:0] rst_sync_q;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_n_s = rst_sync_q[1];

  // Write decode.
  logic              sel_lo, sel_hi;
  logic [PAGE_W-1:0] page;
  logic [PAGE_W-1:0] page_ofs;
  logic              page_hit;
  logic              wr_en;
  logic [IDX_W-1:0]  wr_idx;
  logic [BANK_W-1:0] rd_bank;

  pbm_sel_decode #(.VARIANT(VARIANT), .DEC_W(DEC_AW)) u_dec (
    .addr_lo (cpu_addr[DEC_AW-1:0]),
    .sel_lo  (sel_lo),
    .sel_hi  (sel_hi)
  );

  always_comb begin
    page     = cpu_addr[CPU_AW-1:CPU_AW-PAGE_W];
    page_ofs = page - FIRST_PAGE;
    page_hit = (page >= FIRST_PAGE) && (page <= LAST_PAGE);
    wr_en    = cpu_wr && page_hit;
    wr_idx   = {page_ofs[IDX_W-2:0], sel_hi};
  end

  logic unused_top_bits;
  assign unused_top_bits = ^{cpu_addr[CPU_AW-PAGE_W-1:DEC_AW], cpu_data[CPU_DW-1:NIB_W],
                             page_ofs[PAGE_W-1:IDX_W-1]};

  pbm_bank_file #(.N_BANK(NUM_BANKS), .BW(BANK_W)) u_banks (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_hi   (sel_lo),
    .wr_nib  (cpu_data[NIB_W-1:0]),
    .rd_idx  (gfx_addr[GFX_AW-1:OFS_W]),
    .rd_bank (rd_bank)
  );

  pbm_xlate #(.BW(BANK_W), .OW(OFS_W), .GW(GFX_AW), .ROM_AW(ROM_AW)) u_xlate (
    .bank     (rd_bank),
    .gfx_addr (gfx_addr),
    .bypass   (ram_bypass),
    .pat_addr (pat_addr)
  );

  // R8: under bypass, a steady graphics address gives a steady output even across writes
  a_r8_bypass_hold: assert property (@(posedge clk) disable iff (!rst_n_s)
    (ram_bypass && $past(ram_bypass) && $stable(gfx_addr)) |-> $stable(pat_addr));
endmodule

// File: tb/pattern_bank_map_test.sv
`timescale 1ns/1ps
module pattern_bank_map_test;
  import pbm_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cpu_wr;
  logic [15:0] cpu_addr;
  logic [7:0]  cpu_data;
  logic [12:0] gfx_addr;
  logic        ram_bypass;
  logic [17:0] pat_a;
  logic [14:0] pat_b;
  logic [17:0] pat_c;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;

  pattern_bank_map #(.VARIANT(WIRE_A), .ROM_AW(18)) uut (
    .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
    .gfx_addr(gfx_addr), .ram_bypass(ram_bypass), .pat_addr(pat_a));
  pattern_bank_map #(.VARIANT(WIRE_B), .ROM_AW(15)) uut_b (
    .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
    .gfx_addr(gfx_addr), .ram_bypass(ram_bypass), .pat_addr(pat_b));
  pattern_bank_map #(.VARIANT(WIRE_C), .ROM_AW(18)) uut_c (
    .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
    .gfx_addr(gfx_addr), .ram_bypass(ram_bypass), .pat_addr(pat_c));

  typedef struct packed {
    logic [15:0] addr;
    logic [7:0]  data;
    logic [12:0] gfx;
    logic [17:0] exp;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{16'hB000, 8'h05, 13'h0123, 18'h01523},  // R3 low nibble, reg0
    '{16'hB002, 8'hA3, 13'h0001, 18'h0D401},  // R4 high nibble via A1, data[7:4] dropped
    '{16'hB004, 8'h0C, 13'h07FF, 18'h033FF},  // R5 A2 selects reg1
    '{16'hC080, 8'h0F, 13'h0C00, 18'h03C00},  // R5 A7 selects reg3
    '{16'hC040, 8'h09, 13'h0855, 18'h24855},  // R5 A6 selects high nibble of reg2
    '{16'hE0C6, 8'h0E, 13'h1FFF, 18'h39FFF},  // R2 last page, reg7
    '{16'hD004, 8'h00, 13'h1600, 18'h00200},  // R2 page D, reg5
    '{16'h9000, 8'h0F, 13'h0000, 18'h0D400},  // R2 page 9 ignored
    '{16'hF002, 8'h0F, 13'h1C10, 18'h39C10},  // R2 page F ignored
    '{16'hA004, 8'h0F, 13'h1000, 18'h01000},  // R2 page A ignored
    '{16'hD002, 8'h01, 13'h1000, 18'h05000}   // R4 reg4 high nibble
  };

  task automatic check(input string req, input logic [17:0] act, input logic [17:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [15:0] a, input logic [7:0] d, input logic en);
    @(negedge clk);
    cpu_addr = a;
    cpu_data = d;
    cpu_wr   = en;
    @(negedge clk);
    cpu_wr   = 1'b0;
  endtask

  task automatic probe(input logic [12:0] g);
    gfx_addr = g;
    #1;
  endtask

  task automatic apply_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; cpu_wr = 1'b0; cpu_addr = '0; cpu_data = '0;
    gfx_addr = '0; ram_bypass = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset contents
    for (int i = 0; i < 8; i++) begin
      probe(13'(i * 1024 + 'h2A5));
      check("R1 reset bank value", pat_a, 18'((i << 10) | 'h2A5));
    end

    // R7 table walk
    for (int v = 0; v < NV; v++) begin
      do_write(VECS[v].addr, VECS[v].data, 1'b1);
      probe(VECS[v].gfx);
      check("R7 table vector", pat_a, VECS[v].exp);
    end

    apply_reset();
    probe(13'h0000);
    check("R1 reset after use", pat_a, 18'h00000);

    // R9: no strobe, no change
    do_write(16'hB000, 8'h07, 1'b0);
    probe(13'h0000);
    check("R9 write without strobe", pat_a, 18'h00000);

    // R8: bypass passes the address straight through
    ram_bypass = 1'b1;
    probe(13'h1ABC);
    check("R8 bypass passthrough", pat_a, 18'h01ABC);
    do_write(16'hB000, 8'h06, 1'b1);
    probe(13'h1ABC);
    check("R8 bypass ignores bank write", pat_a, 18'h01ABC);
    check("R8 bypass narrow ROM", {3'b0, pat_b}, 18'h01ABC);
    ram_bypass = 1'b0;
    probe(13'h0000);
    check("R8 write landed during bypass", pat_a, 18'h01800);

    // R6: alternate wirings, A0 set
    do_write(16'hB001, 8'h09, 1'b1);
    probe(13'h0123);
    check("R5 wiring A, A0 unused", pat_a, 18'h02523);
    check("R6 wiring B, A0 high nibble, masked R7", {3'b0, pat_b}, 18'h05923);
    check("R6 wiring C, A0 picks reg1", pat_c, 18'h01923);
    probe(13'h0410);
    check("R6 wiring C reg1 low nibble", pat_c, 18'h02410);
    check("R6 wiring B reg1 untouched", {3'b0, pat_b}, 18'h00410);

    // R6: A1 set on page C
    do_write(16'hC002, 8'h0B, 1'b1);
    probe(13'h0C00);
    check("R6 wiring B, A1 picks reg3", {3'b0, pat_b}, 18'h02C00);
    check("R5 wiring A reg3 untouched", pat_a, 18'h00C00);
    probe(13'h0800);
    check("R5 wiring A, A1 high nibble reg2", pat_a, 18'h2C800);
    check("R6 wiring C, A1 high nibble reg2", pat_c, 18'h2C800);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule